// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits between a simple bus (valid/address/data) and a peripheral register file and decides, write by write, whether the register file may take the write. After reset the file is locked. It becomes writable only after two magic words have been written in the right order to two dedicated kick addresses that live inside the guard. The first kick address must hold its key at the moment the second kick address receives its key. Any other value written to either kick address locks the file again. Writing zero to both is the usual way software locks it.

Every non-kick address counts as protected. A protected write made while unlocked is passed on one cycle later on the accept channel, with its address and data. A protected write made while locked is dropped without any error. Writes to the kick addresses are consumed by the guard and are never passed on. Reads are never gated: each read request is forwarded one cycle later in every state.

Top module: `kick_write_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, the unlocked flag, the accept valid and the read valid outputs are all 0.
- R2: A write to any protected (non-kick) address while locked produces no accept pulse in the next cycle.
- R3: While unlocked, a protected write at cycle N appears on the accept outputs at cycle N+1 with the same address and data. Unlocking takes effect for writes in the cycle after the second key is written.
- R4: Writing key 0x95A4F1E0 to kick address 0x70 does not unlock unless kick address 0x6C currently holds key 0x83E70B13.
- R5: Writing any value other than 0x83E70B13 to 0x6C locks the file and disarms it, so a later correct key at 0x70 on its own does not unlock.
- R6: Writing any value other than 0x95A4F1E0 to 0x70 locks the file but leaves 0x6C armed, so writing the correct key to 0x70 again unlocks.
- R7: Writing zero to 0x6C and then to 0x70 leaves the file locked, and protected writes are then dropped.
- R8: Writes to 0x6C or 0x70 are never forwarded on the accept channel, whether locked or unlocked.
- R9: A read request at cycle N appears on the read outputs at cycle N+1 with the same address, in both the locked and the unlocked state.
- R10: The keys only unlock in order. Writing the 0x70 key first and the 0x6C key second leaves the file locked until 0x70 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read byte address |
| acc_valid_o | output | 1 | Registered accept strobe to the register file |
| acc_addr_o | output | ADDR_W | Address of the accepted write |
| acc_data_o | output | DATA_W | Data of the accepted write |
| rd_valid_o | output | 1 | Registered read strobe to the register file |
| rd_addr_o | output | ADDR_W | Forwarded read address |
| unlocked_o | output | 1 | 1 when protected writes are accepted |

## Verification
On every cycle the assertions check the properties that depend on one step only. A write while locked, or any kick write, produces no accept. An unlocked protected write is forwarded intact. Reads always pass through. A wrong key on either kick address leaves the file locked. The lock can only open in the cycle after a correct second key. Ordering and memory effects cover more than one step: a mis-ordered key pair, the first kick staying armed after a bad second key, and disarming after a bad first key. Only the bench scenarios can show these, by comparing against the reference model along complete key sequences.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
  typedef enum logic [2:0] {
    EV_IDLE     = 3'd0,
    EV_K0_GOOD  = 3'd1,
    EV_K0_BAD   = 3'd2,
    EV_K1_GOOD  = 3'd3,
    EV_K1_BAD   = 3'd4,
    EV_PROT_WR  = 3'd5
  } guard_ev_t;
endpackage

// File: rtl/kwg_decode.sv
module kwg_decode
  import kwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] K0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] K1_ADDR = 'h70,
  parameter logic [DATA_W-1:0] KEY0 = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 'h95A4F1E0
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output guard_ev_t         ev
);
  logic hit0, hit1;
  assign hit0 = (wr_addr == K0_ADDR);
  assign hit1 = (wr_addr == K1_ADDR);

  always_comb begin
    ev = EV_IDLE;
    if (wr_valid) begin
      if (hit0)      ev = (wr_data == KEY0) ? EV_K0_GOOD : EV_K0_BAD;
      else if (hit1) ev = (wr_data == KEY1) ? EV_K1_GOOD : EV_K1_BAD;
      else           ev = EV_PROT_WR;
    end
  end
endmodule

// File: rtl/kwg_lock.sv
module kwg_lock
  import kwg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  guard_ev_t ev,
  output logic      armed,
  output logic      unlocked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      unique case (ev)
        EV_K0_GOOD: armed <= 1'b1;
        EV_K0_BAD: begin
          armed    <= 1'b0;
          unlocked <= 1'b0;
        end
        EV_K1_GOOD: unlocked <= armed;
        EV_K1_BAD:  unlocked <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kwg_gate.sv
module kwg_gate
  import kwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  guard_ev_t         ev,
  input  logic              unlocked,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              rd_valid_q,
  output logic [ADDR_W-1:0] rd_addr_q
);
  logic take;
  assign take = (ev == EV_PROT_WR) && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid  <= 1'b0;
      acc_addr   <= '0;
      acc_data   <= '0;
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      acc_valid  <= take;
      if (take) begin
        acc_addr <= wr_addr;
        acc_data <= wr_data;
      end
      rd_valid_q <= rd_valid;
      if (rd_valid) rd_addr_q <= rd_addr;
    end
  end
endmodule

// File: rtl/kick_write_guard.sv
module kick_write_guard
  import kwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] K0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] K1_ADDR = 'h70,
  parameter logic [DATA_W-1:0] KEY0 = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              acc_valid_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              unlocked_o
);
  guard_ev_t ev;
  logic      armed;
  logic      unlocked;

  kwg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .K0_ADDR(K0_ADDR), .K1_ADDR(K1_ADDR),
    .KEY0(KEY0), .KEY1(KEY1)
  ) u_dec (
    .wr_valid(wr_valid_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .ev      (ev)
  );

  kwg_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .armed   (armed),
    .unlocked(unlocked)
  );

  kwg_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .unlocked  (unlocked),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .rd_valid  (rd_valid_i),
    .rd_addr   (rd_addr_i),
    .acc_valid (acc_valid_o),
    .acc_addr  (acc_addr_o),
    .acc_data  (acc_data_o),
    .rd_valid_q(rd_valid_o),
    .rd_addr_q (rd_addr_o)
  );

  assign unlocked_o = unlocked;
endmodule

// File: rtl/kick_write_guard_chk.sv
module kick_write_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] K0_ADDR = 'h6C,
  parameter logic [ADDR_W-1:0] K1_ADDR = 'h70,
  parameter logic [DATA_W-1:0] KEY0 = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 'h95A4F1E0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_valid_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              acc_valid_o,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic [DATA_W-1:0] acc_data_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              unlocked_o
);
  logic is_kick;
  assign is_kick = (wr_addr_i == K0_ADDR) || (wr_addr_i == K1_ADDR);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!unlocked_o && !acc_valid_o && !rd_valid_o));

  a_r2_locked_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && !unlocked_o) |=> !acc_valid_o);

  a_r3_forward: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && !is_kick && unlocked_o) |=>
      (acc_valid_o && acc_addr_o == $past(wr_addr_i) && acc_data_o == $past(wr_data_i)));

  a_r4_open_only_by_key: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |->
      $past(wr_valid_i && wr_addr_i == K1_ADDR && wr_data_i == KEY1));

  a_r5_bad_k0_locks: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && wr_addr_i == K0_ADDR && wr_data_i != KEY0) |=> !unlocked_o);

  a_r6_bad_k1_locks: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && wr_addr_i == K1_ADDR && wr_data_i != KEY1) |=> !unlocked_o);

  a_r8_kick_consumed: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && is_kick) |=> !acc_valid_o);

  a_r9_read_pass: assert property (@(posedge clk) disable iff (rst)
    rd_valid_i |=> (rd_valid_o && rd_addr_o == $past(rd_addr_i)));
endmodule

bind kick_write_guard kick_write_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .K0_ADDR(K0_ADDR), .K1_ADDR(K1_ADDR),
  .KEY0(KEY0), .KEY1(KEY1)
) chk_i (.*);

// File: tb/kick_write_guard_tb_top.sv
module kick_write_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  K0 = 8'h6C;
  localparam logic [7:0]  K1 = 8'h70;
  localparam logic [31:0] KEY0 = 32'h83E70B13;
  localparam logic [31:0] KEY1 = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid_i;
  logic [7:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic        rd_valid_i;
  logic [7:0]  rd_addr_i;
  logic        acc_valid_o;
  logic [7:0]  acc_addr_o;
  logic [31:0] acc_data_o;
  logic        rd_valid_o;
  logic [7:0]  rd_addr_o;
  logic        unlocked_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  bit          m_armed = 1'b0;
  bit          m_open  = 1'b0;
  bit          e_acc   = 1'b0;
  logic [7:0]  e_acc_a = '0;
  logic [31:0] e_acc_d = '0;
  bit          e_rd    = 1'b0;
  logic [7:0]  e_rd_a  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kick_write_guard dut_i (
    .clk(clk), .rst(rst),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
    .acc_valid_o(acc_valid_o), .acc_addr_o(acc_addr_o), .acc_data_o(acc_data_o),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .unlocked_o(unlocked_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input string tag, input bit r, input bit wv,
                      input logic [7:0] wa, input logic [31:0] wd,
                      input bit rv = 1'b0, input logic [7:0] ra = 8'h00);
    rst = r; wr_valid_i = wv; wr_addr_i = wa; wr_data_i = wd;
    rd_valid_i = rv; rd_addr_i = ra;
    if (r) begin
      m_armed = 0; m_open = 0; e_acc = 0; e_rd = 0;
    end else begin
      e_acc = wv && wa != K0 && wa != K1 && m_open;
      if (e_acc) begin e_acc_a = wa; e_acc_d = wd; end
      e_rd = rv;
      if (rv) e_rd_a = ra;
      if (wv && wa == K0) begin
        if (wd == KEY0) m_armed = 1;
        else begin m_armed = 0; m_open = 0; end
      end else if (wv && wa == K1) begin
        m_open = (wd == KEY1) ? m_armed : 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "unlocked", {31'd0, unlocked_o}, {31'd0, m_open});
    check(tag, "acc_valid", {31'd0, acc_valid_o}, {31'd0, e_acc});
    if (e_acc) begin
      check(tag, "acc_addr", {24'd0, acc_addr_o}, {24'd0, e_acc_a});
      check(tag, "acc_data", acc_data_o, e_acc_d);
    end
    check(tag, "rd_valid", {31'd0, rd_valid_o}, {31'd0, e_rd});
    if (e_rd) check(tag, "rd_addr", {24'd0, rd_addr_o}, {24'd0, e_rd_a});
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 8'h00, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_valid_i = 0; wr_addr_i = 0; wr_data_i = 0; rd_valid_i = 0; rd_addr_i = 0;
    @(negedge clk);
    // R1: reset state
    step("R1", 1, 1, 8'h10, 32'h1, 1, 8'h04);
    step("R1", 1, 0, 8'h00, 32'h0);
    idle("R1");
    // R2: protected writes dropped while locked; R9 reads pass
    step("R2", 0, 1, 8'h10, 32'hDEAD0001, 1, 8'h10);
    step("R2", 0, 1, 8'h60, 32'hDEAD0002);
    step("R9", 0, 0, 8'h00, 32'h0, 1, 8'h44);
    // R4: second key alone does not unlock
    step("R4", 0, 1, K1, KEY1);
    step("R4", 0, 1, 8'h40, 32'h12345678);
    // R10: wrong order stays locked, then second key again opens
    step("R10", 0, 1, K0, KEY0);
    step("R10", 0, 1, 8'h48, 32'h0000_0008);
    step("R3", 0, 1, K1, KEY1);
    // R3: forwarded writes, back to back, with reads (R9)
    step("R3", 0, 1, 8'h00, 32'h0000_0059, 1, 8'h00);
    step("R3", 0, 1, 8'h60, 32'hA5A5_5A5A);
    step("R3", 0, 1, 8'h68, 32'hFFFF_FFFF, 1, 8'h68);
    step("R3", 0, 1, 8'h98, 32'h0001_0000);
    idle("R3");
    // R8: kick writes are consumed, never forwarded
    step("R8", 0, 1, K0, KEY0);
    step("R8", 0, 1, K1, KEY1);
    // R6: bad second key locks, first stays armed
    step("R6", 0, 1, K1, 32'h95A4F1E1);
    step("R6", 0, 1, 8'h20, 32'h0000_0011);
    step("R6", 0, 1, K1, KEY1);
    step("R6", 0, 1, 8'h24, 32'h0000_0022);
    // R5: bad first key locks and disarms
    step("R5", 0, 1, K0, 32'h83E70B12);
    step("R5", 0, 1, K1, KEY1);
    step("R5", 0, 1, 8'h28, 32'h0000_0033);
    // R7: unlock, then zero both, writes dropped
    step("R7", 0, 1, K0, KEY0);
    step("R7", 0, 1, K1, KEY1);
    step("R7", 0, 1, 8'h2C, 32'h0000_0044);
    step("R7", 0, 1, K0, 32'h0);
    step("R7", 0, 1, K1, 32'h0);
    step("R7", 0, 1, 8'h30, 32'h0000_0055, 1, 8'h30);
    step("R7", 0, 1, K1, KEY1);
    step("R7", 0, 1, 8'h34, 32'h0000_0066);
    // R1: reset while unlocked returns to locked
    step("R1", 0, 1, K0, KEY0);
    step("R1", 0, 1, K1, KEY1);
    step("R1", 1, 1, 8'h10, 32'h77);
    step("R1", 0, 1, 8'h10, 32'h88);
    idle("R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule